// File: doc/BRIEF.md
# Paged Multiplexed External Data Memory Master

This block is a bus master that carries out single external data memory accesses over a narrow multiplexed port pair, reaching a 24-bit address space. An internal client presents a request with a 24-bit address, a direction flag and a write byte. The master then runs a fixed access sequence on two 8-bit ports, an address latch strobe and two active-low strobes. When the sequence ends it raises a one-cycle completion pulse, and a read result appears on a held output.

The low port is shared between address and data. It first presents the bottom address byte, which an external latch captures while the latch strobe is high. It then either carries the write byte or is released so that the memory can drive it. The upper port is time-shared too. During the latch strobe it shows the page byte (address bits 23:16), and after the strobe falls it shows the middle byte (bits 15:8). A board that latches the page byte therefore gets 16 MB of data space. A board without that latch sees a plain 64 KB space.

A strobe-enable input can hold the latch strobe low for whole accesses, for example while start-up code runs, without changing anything else in the sequence.

Top module: `pmx_mem_if`

## Requirements
- R1: After reset the master is idle: `busy` 0, `done` 0, `ale` 0, `rd_n` 1, `wr_n` 1, `port_lo_oe` 0, `port_hi` 0, `rdata` 0.
- R2: A request (`req` 1) is accepted at a rising clock edge only while `busy` is 0. While an access runs, `req`, `addr`, `we` and `wdata` are ignored. A `req` held high through `done` starts a second access on the following cycle.
- R3: For the first ALE_CYC cycles after acceptance (the address phase), `port_lo_oe` is 1, `port_lo_out` equals address bits 7:0 and `port_hi` equals address bits 23:16. `ale` is 1 in these cycles when `ale_en` is 1.
- R4: From the cycle after the address phase until `done`, `port_hi` equals address bits 15:8. It is 0 while idle.
- R5: On a write (`we` 1), one setup cycle follows the address phase, then STB_CYC strobe cycles with `wr_n` 0. Through setup and strobe, `port_lo_oe` is 1 and `port_lo_out` equals `wdata`. `rd_n` stays 1.
- R6: On a read (`we` 0), `port_lo_oe` is 0 from the setup cycle until the end of the access. `rd_n` is 0 for exactly the STB_CYC strobe cycles and `wr_n` stays 1.
- R7: A read captures `port_lo_in` at the clock edge that ends the last strobe cycle. The captured value is on `rdata` from the `done` cycle and is held until the next read captures. Writes leave `rdata` unchanged.
- R8: `done` is a single-cycle pulse in the release cycle, ALE_CYC+STB_CYC+1 cycles after the accepting edge. In the release cycle all strobes are inactive and `port_lo_oe` is 0. `busy` is 1 from the accepting edge through the `done` cycle.
- R9: With `ale_en` 0, `ale` stays 0 for the whole access and every other output follows the same sequence.
- R10: `rd_n` and `wr_n` are never 0 together, and `port_lo_oe` is never 1 while `rd_n` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request, sampled when idle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 24 | Page, middle and low address bytes |
| wdata | input | 8 | Write byte |
| ale_en | input | 1 | 1 lets the latch strobe toggle |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Last read byte |
| port_lo_out | output | 8 | Low port output value |
| port_lo_oe | output | 1 | Low port output enable |
| port_lo_in | input | 8 | Low port input value |
| port_hi | output | 8 | Upper port (page, then middle byte) |
| ale | output | 1 | Address latch strobe, active high |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |

## Verification
A phase counter that is off by one cycle moves the falling edge of `ale`, the switch of `port_hi` from page to middle byte, and the edges of the strobes. It therefore shows at the ports within the same access, at the first cycle whose expected value differs. A wrong read sampling cycle shows as a wrong `rdata` at `done`, because the bench memory returns a different byte in each strobe cycle. A latched address that drifts during an access shows as a wrong byte captured by the bench's external latch model, or as a wrong write byte on the low port during the strobe.

// File: rtl/pmx_pkg.sv
package pmx_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_SETUP,
    PH_STRB,
    PH_REL
  } phase_t;

  // Busy cycles of one access, counted from the accepting edge.
  function automatic int unsigned access_len(int unsigned ale_cyc, int unsigned stb_cyc);
    return ale_cyc + stb_cyc + 2;
  endfunction

  // Byte idx (0 = low, 1 = middle, 2 = page) of a 24-bit address.
  function automatic logic [7:0] addr_byte(logic [23:0] a, int unsigned idx);
    return a[idx*8 +: 8];
  endfunction
endpackage

// File: rtl/pmx_seq.sv
module pmx_seq
  import pmx_pkg::*;
#(
  parameter int unsigned ALE_CYC = 2,
  parameter int unsigned STB_CYC = 3
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   req,
  output phase_t phase,
  output logic   accept,
  output logic   last_strb
);
  localparam int unsigned MAXC  = (ALE_CYC > STB_CYC) ? ALE_CYC : STB_CYC;
  localparam int unsigned CNT_W = $clog2(MAXC + 1);

  logic [CNT_W-1:0] cnt;
  logic             last_addr;

  assign accept    = (phase == PH_IDLE) && req;
  assign last_addr = (phase == PH_ADDR) && (cnt == CNT_W'(ALE_CYC - 1));
  assign last_strb = (phase == PH_STRB) && (cnt == CNT_W'(STB_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          cnt <= '0;
          if (req) phase <= PH_ADDR;
        end
        PH_ADDR: begin
          if (last_addr) begin
            phase <= PH_SETUP;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_SETUP: begin
          phase <= PH_STRB;
          cnt   <= '0;
        end
        PH_STRB: begin
          if (last_strb) begin
            phase <= PH_REL;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // Release always returns to idle (R8)
  assert_release_to_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_REL) |=> (phase == PH_IDLE));
  // Setup is exactly one cycle, then strobe (R5)
  assert_setup_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SETUP) |=> (phase == PH_STRB));
endmodule

// File: rtl/pmx_port.sv
module pmx_port
  import pmx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  phase_t      phase,
  input  logic        accept,
  input  logic        last_strb,
  input  logic        we,
  input  logic [23:0] addr,
  input  logic [7:0]  wdata,
  input  logic        ale_en,
  input  logic [7:0]  port_lo_in,
  output logic        busy,
  output logic        done,
  output logic [7:0]  rdata,
  output logic [7:0]  port_lo_out,
  output logic        port_lo_oe,
  output logic [7:0]  port_hi,
  output logic        ale,
  output logic        rd_n,
  output logic        wr_n
);
  logic [23:0] addr_q;
  logic [7:0]  wdata_q;
  logic        we_q;
  logic        rd_capture;

  assign rd_capture = last_strb && !we_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      we_q    <= 1'b0;
      rdata   <= '0;
    end else begin
      if (accept) begin
        addr_q  <= addr;
        wdata_q <= wdata;
        we_q    <= we;
      end
      if (rd_capture) rdata <= port_lo_in;
    end
  end

  always_comb begin
    busy        = (phase != PH_IDLE);
    done        = 1'b0;
    ale         = 1'b0;
    rd_n        = 1'b1;
    wr_n        = 1'b1;
    port_lo_oe  = 1'b0;
    port_lo_out = '0;
    port_hi     = '0;
    unique case (phase)
      PH_ADDR: begin
        ale         = ale_en;
        port_lo_oe  = 1'b1;
        port_lo_out = addr_byte(addr_q, 0);
        port_hi     = addr_byte(addr_q, 2);
      end
      PH_SETUP: begin
        port_lo_oe  = we_q;
        port_lo_out = we_q ? wdata_q : 8'h00;
        port_hi     = addr_byte(addr_q, 1);
      end
      PH_STRB: begin
        port_lo_oe  = we_q;
        port_lo_out = we_q ? wdata_q : 8'h00;
        port_hi     = addr_byte(addr_q, 1);
        rd_n        = we_q;
        wr_n        = !we_q;
      end
      PH_REL: begin
        done    = 1'b1;
        port_hi = addr_byte(addr_q, 1);
      end
      default: ;
    endcase
  end

  assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));
  assert_no_contention_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !port_lo_oe);
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_ale_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (port_lo_oe && port_lo_out == addr_q[7:0] && port_hi == addr_q[23:16]));
  assert_req_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> $stable(addr_q) && $stable(we_q) && $stable(wdata_q));
  assert_rdata_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_capture |=> $stable(rdata));
endmodule

// File: rtl/pmx_mem_if.sv
module pmx_mem_if
  import pmx_pkg::*;
#(
  parameter int unsigned ALE_CYC = 2,
  parameter int unsigned STB_CYC = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic        we,
  input  logic [23:0] addr,
  input  logic [7:0]  wdata,
  input  logic        ale_en,
  output logic        busy,
  output logic        done,
  output logic [7:0]  rdata,
  output logic [7:0]  port_lo_out,
  output logic        port_lo_oe,
  input  logic [7:0]  port_lo_in,
  output logic [7:0]  port_hi,
  output logic        ale,
  output logic        rd_n,
  output logic        wr_n
);
  phase_t phase;
  logic   accept;
  logic   last_strb;

  pmx_seq #(.ALE_CYC(ALE_CYC), .STB_CYC(STB_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .req(req),
    .phase(phase), .accept(accept), .last_strb(last_strb)
  );

  pmx_port u_port (
    .clk(clk), .rst_n(rst_n), .phase(phase), .accept(accept),
    .last_strb(last_strb), .we(we), .addr(addr), .wdata(wdata),
    .ale_en(ale_en), .port_lo_in(port_lo_in), .busy(busy), .done(done),
    .rdata(rdata), .port_lo_out(port_lo_out), .port_lo_oe(port_lo_oe),
    .port_hi(port_hi), .ale(ale), .rd_n(rd_n), .wr_n(wr_n)
  );

  // ale only ever rises out of idle (R9: no stray strobe)
  assert_ale_from_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ale) |-> busy);
endmodule

// File: tb/test_pmx_mem_if.sv
module test_pmx_mem_if;
  localparam int CLK_PERIOD = 10;
  localparam int ALE = 2;
  localparam int STB = 3;
  localparam int LEN = ALE + STB + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0, ale_en = 1'b1;
  logic [23:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] port_lo_in = 8'hEE;
  logic busy, done, port_lo_oe, ale, rd_n, wr_n;
  logic [7:0] rdata, port_lo_out, port_hi;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pmx_mem_if #(.ALE_CYC(ALE), .STB_CYC(STB)) i_pmx_mem_if (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .ale_en(ale_en), .busy(busy), .done(done), .rdata(rdata),
    .port_lo_out(port_lo_out), .port_lo_oe(port_lo_oe), .port_lo_in(port_lo_in),
    .port_hi(port_hi), .ale(ale), .rd_n(rd_n), .wr_n(wr_n)
  );

  function automatic logic [7:0] mem_byte(logic [23:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ a[23:16] ^ 8'h3C;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  // Behavioural reference: position t within an access.
  bit m_busy = 0; int t = 0; bit m_we = 0;
  logic [23:0] m_addr = '0; logic [7:0] m_wd = '0; logic [7:0] exp_rd = '0;
  logic [7:0] lat_lo = '0, lat_page = '0, lat_hi = '0;
  logic [7:0] snap_lo = '0, snap_page = '0;
  bit m_en = 1;
  int rd_run = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; t = 0; exp_rd = '0;
    end else if (!m_busy) begin
      if (req) begin
        m_busy = 1; t = 0; m_we = we; m_addr = addr; m_wd = wdata; m_en = ale_en;
        snap_lo = lat_lo; snap_page = lat_page;
      end
    end else begin
      if (t == ALE + STB && !m_we) exp_rd = mem_byte({lat_page, lat_hi, lat_lo}) + 8'(STB - 1);
      if (t == LEN - 1) m_busy = 0; else t++;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      bit in_addr, in_strb, in_set, in_rel;
      logic e_oe;
      in_addr = m_busy && t < ALE;
      in_set  = m_busy && t == ALE;
      in_strb = m_busy && t > ALE && t <= ALE + STB;
      in_rel  = m_busy && t == ALE + STB + 1;
      e_oe = in_addr || (m_we && (in_set || in_strb));
      chk(busy == m_busy, "R2 busy", busy, m_busy);
      chk(ale == (in_addr && ale_en), m_en ? "R3 ale" : "R9 ale", ale, in_addr && ale_en);
      chk(port_lo_oe == e_oe, m_we ? "R5 oe" : "R6 oe", port_lo_oe, e_oe);
      if (in_addr) chk(port_lo_out == m_addr[7:0], "R3 lo addr", port_lo_out, m_addr[7:0]);
      if (e_oe && !in_addr) chk(port_lo_out == m_wd, "R5 lo data", port_lo_out, m_wd);
      chk(port_hi == (in_addr ? m_addr[23:16] : (m_busy ? m_addr[15:8] : 8'h00)),
          in_addr ? "R3 hi page" : "R4 hi mid", port_hi,
          in_addr ? m_addr[23:16] : (m_busy ? m_addr[15:8] : 8'h00));
      chk(rd_n == !(in_strb && !m_we), "R6 rd_n", rd_n, !(in_strb && !m_we));
      chk(wr_n == !(in_strb && m_we), "R5 wr_n", wr_n, !(in_strb && m_we));
      chk(done == in_rel, "R8 done", done, in_rel);
      chk(rdata == exp_rd, "R7 rdata", rdata, exp_rd);
      chk(!(!rd_n && !wr_n) && !(!rd_n && port_lo_oe), "R10 strobes", {rd_n, wr_n, port_lo_oe}, 3'b110);
      // external latch and memory model
      if (ale) begin lat_lo = port_lo_out; lat_page = port_hi; end
      if (!rd_n || !wr_n) lat_hi = port_hi;
      if (!rd_n) begin port_lo_in = mem_byte({lat_page, lat_hi, lat_lo}) + 8'(rd_run); rd_run++; end
      else begin port_lo_in = 8'hEE; rd_run = 0; end
      if (in_rel) begin
        if (m_en)
          chk({lat_page, lat_hi, lat_lo} == m_addr, "R3 latched addr", {lat_page, lat_hi, lat_lo}, m_addr);
        else
          chk({lat_page, lat_lo} == {snap_page, snap_lo}, "R9 latch untouched", {lat_page, lat_lo}, {snap_page, snap_lo});
      end
    end
  end

  task automatic access(bit w, logic [23:0] a, logic [7:0] d, bit en);
    @(negedge clk); req = 1; we = w; addr = a; wdata = d; ale_en = en;
    @(negedge clk); req = 0; addr = ~a; wdata = ~d; we = ~w;
    repeat (LEN + 1) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !ale && rd_n && wr_n && !port_lo_oe && port_hi == 0 && rdata == 0,
        "R1 reset", {busy, done, ale, rd_n, wr_n, port_lo_oe}, 6'b000110);
    rst_n = 1;
    @(negedge clk);
    access(1, 24'h12_3456, 8'hA7, 1);
    access(0, 24'h12_3456, 8'h00, 1);
    access(0, 24'hFF_00FF, 8'h00, 1);
    access(1, 24'h00_0000, 8'h5A, 1);   // R7: write keeps rdata
    access(0, 24'h80_FF01, 8'h00, 0);   // R9 strobe suppressed
    access(1, 24'h7E_1234, 8'h3C, 0);
    // R2: request held and changed while busy
    @(negedge clk); req = 1; we = 0; addr = 24'hC3_5A96; ale_en = 1;
    @(negedge clk); addr = 24'h01_0203; we = 1; wdata = 8'hFF;
    @(negedge clk); req = 0;
    repeat (LEN + 1) @(negedge clk);
    // R2: req held through done gives back-to-back accesses
    @(negedge clk); req = 1; we = 0; addr = 24'h44_5566;
    repeat (LEN + 1) @(negedge clk);
    req = 0;
    repeat (LEN + 2) @(negedge clk);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule